// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block sits on a 32-bit configuration word stream and turns it into register-write transactions. Each accepted word is classified, and the decoder updates its state from that class. Padding words are dropped. Before synchronisation the decoder looks only for the bus-width patterns and the synchronisation word. After synchronisation it decodes write headers, each of which carries a 5-bit register address and an 11-bit count of the payload words that follow. Every payload word is presented on the write port with a one-cycle strobe.

The decoder can also detect a stream whose bits arrive reversed inside every byte. Until the first recognised pattern has been seen, a word that matches nothing is reversed within each byte and classified again. If the reversed form is a bus-width or synchronisation pattern, the decoder latches a swapped mode and corrects every later word before decoding it. Writes to the command register produce pulses for three codes: CRC reset, startup and desynchronise. A write to the device-ID register captures the ID. A frame-data read request header is flagged on its own output.

Top module: `cfg_stream_decoder`

## Requirements
- R1: A word equal to 0xFFFFFFFF is discarded in every state, including inside a payload. It produces no strobe or pulse, and it does not consume payload count.
- R2: Header decoding starts only after the word 0xAA995566 has been accepted. Before that, headers and payloads produce no output. The words 0x000000BB and 0x11220044 are recognised but do not synchronise the decoder.
- R3: While unsynchronised, no pattern has been seen and swapped mode is off, an unrecognised word is reversed within each byte: bit 8b+i moves to bit 8b+7-i. If the reversed word is a bus-width or sync word, the `swapped` output is set and every later word is corrected the same way before decoding. That word is treated as the pattern it matches.
- R4: A word whose bits 31:28 are 0x3 is a write header. Its bits 17:13 give the address and its bits 10:0 give the count N. The next N non-padding words each appear on `wr_data` with `wr_valid` high for one cycle and `wr_addr` equal to the address. The word after them is decoded as a header again. Outputs are registered and appear one cycle after the word is accepted.
- R5: A write header with N = 0 produces no strobe, and the next word is decoded as a header.
- R6: The no-op word 0x20000000 seen outside a payload produces no output and changes no decoding state.
- R7: A payload to address 4 whose value is 7, 5 or 13 pulses `crc_reset`, `startup` or `desync` respectively for one cycle. Any other value pulses none of them.
- R8: A payload to address 12 sets `dev_id` to bits 27:0 of that payload.
- R9: The header 0x28006000, when synchronised, pulses `rd_req` for one cycle and produces no write strobe.
- R10: After a desynchronise command, `synced` falls and all non-sync words are ignored until 0xAA995566 arrives again. `swapped` is kept.
- R11: Synchronous active-high reset clears `synced`, `swapped`, the remaining count and `dev_id`, and holds `in_ready` low. Out of reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder accepts a word this cycle |
| in_word | input | 32 | Incoming configuration word |
| wr_valid | output | 1 | Payload write strobe |
| wr_addr | output | 5 | Register address of the payload |
| wr_data | output | 32 | Payload word (bit-corrected) |
| rd_req | output | 1 | Frame-data read request pulse |
| crc_reset | output | 1 | CRC reset command pulse |
| startup | output | 1 | Startup command pulse |
| desync | output | 1 | Desynchronise command pulse |
| dev_id | output | 28 | Captured device ID |
| synced | output | 1 | Header decoding enabled |
| swapped | output | 1 | Per-byte bit reversal is being corrected |

## Verification
The header path is swept over all 32 addresses with counts 0 to 3. Each payload value encodes its address and index, so a wrong address, a wrong count or a payload leak shows up on a specific strobe. The command register is swept over all 32 codes, which checks that exactly the three decoded codes pulse and that the desync code drops synchronisation. A second stream is sent fully bit-reversed per byte, which separates correct swap detection and correction from plain decoding. Padding and no-op words are placed inside payloads and between headers to show that they neither consume count nor disturb state.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 11;
    localparam int ID_W   = 28;

    localparam logic [WORD_W-1:0] PAD_WORD   = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] WIDTH_PAT  = 32'h0000_00BB;
    localparam logic [WORD_W-1:0] WIDTH_DET  = 32'h1122_0044;
    localparam logic [WORD_W-1:0] SYNC_WORD  = 32'hAA99_5566;
    localparam logic [WORD_W-1:0] NOOP_WORD  = 32'h2000_0000;
    localparam logic [WORD_W-1:0] RDREQ_WORD = 32'h2800_6000;

    localparam logic [ADDR_W-1:0] CMD_ADDR = 5'd4;
    localparam logic [ADDR_W-1:0] ID_ADDR  = 5'd12;
    localparam logic [WORD_W-1:0] CODE_CRC    = 32'd7;
    localparam logic [WORD_W-1:0] CODE_START  = 32'd5;
    localparam logic [WORD_W-1:0] CODE_DESYNC = 32'd13;

    typedef struct packed {
        logic pad;
        logic width_pat;
        logic width_det;
        logic sync;
        logic hdr;
        logic rdreq;
        logic noop;
    } word_class_t;

    typedef struct packed {
        logic              synced;
        logic              swap;
        logic              seen;
        logic [CNT_W-1:0]  remain;
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   dev_id;
        logic              wr_valid;
        logic [ADDR_W-1:0] wr_addr;
        logic [WORD_W-1:0] wr_data;
        logic              rd_req;
        logic              crc_p;
        logic              start_p;
        logic              desync_p;
    } dec_state_t;
endpackage

// File: rtl/cfgdec_byte_rev.sv
module cfgdec_byte_rev #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int LANES = WORD_W / LANE_W;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        for (genvar i = 0; i < LANE_W; i++) begin : g_bit
            assign word_o[b*LANE_W + i] = word_i[b*LANE_W + LANE_W-1 - i];
        end
    end
endmodule

// File: rtl/cfgdec_classify.sv
module cfgdec_classify
    import cfgdec_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output word_class_t       cls_o
);
    always_comb begin
        cls_o.pad       = (word_i == PAD_WORD);
        cls_o.width_pat = (word_i == WIDTH_PAT);
        cls_o.width_det = (word_i == WIDTH_DET);
        cls_o.sync      = (word_i == SYNC_WORD);
        cls_o.hdr       = (word_i[31:28] == 4'h3);
        cls_o.rdreq     = (word_i == RDREQ_WORD);
        cls_o.noop      = (word_i == NOOP_WORD);
    end
endmodule

// File: rtl/cfg_stream_decoder.sv
module cfg_stream_decoder
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_req,
    output logic              crc_reset,
    output logic              startup,
    output logic              desync,
    output logic [ID_W-1:0]   dev_id,
    output logic              synced,
    output logic              swapped
);
    dec_state_t  st_d, st_q;
    logic [WORD_W-1:0] raw_rev, eff_word;
    word_class_t cls_eff, cls_rev;
    logic accept;
    logic rev_pattern, eff_pattern;

    cfgdec_byte_rev #(.WORD_W(WORD_W), .LANE_W(8)) u_rev (
        .word_i(in_word),
        .word_o(raw_rev)
    );

    assign eff_word = st_q.swap ? raw_rev : in_word;

    cfgdec_classify u_cls_eff (.word_i(eff_word), .cls_o(cls_eff));
    cfgdec_classify u_cls_rev (.word_i(raw_rev),  .cls_o(cls_rev));

    assign in_ready    = ~rst;
    assign accept      = in_valid & in_ready;
    assign eff_pattern = cls_eff.width_pat | cls_eff.width_det | cls_eff.sync;
    assign rev_pattern = cls_rev.width_pat | cls_rev.width_det | cls_rev.sync;

    always_comb begin
        st_d          = st_q;
        st_d.wr_valid = 1'b0;
        st_d.rd_req   = 1'b0;
        st_d.crc_p    = 1'b0;
        st_d.start_p  = 1'b0;
        st_d.desync_p = 1'b0;
        if (accept && !cls_eff.pad) begin
            if (st_q.remain != '0) begin
                st_d.wr_valid = 1'b1;
                st_d.wr_addr  = st_q.addr;
                st_d.wr_data  = eff_word;
                st_d.remain   = st_q.remain - 1'b1;
                if (st_q.addr == ID_ADDR)
                    st_d.dev_id = eff_word[ID_W-1:0];
                if (st_q.addr == CMD_ADDR) begin
                    if (eff_word == CODE_CRC)   st_d.crc_p   = 1'b1;
                    if (eff_word == CODE_START) st_d.start_p = 1'b1;
                    if (eff_word == CODE_DESYNC) begin
                        st_d.desync_p = 1'b1;
                        st_d.synced   = 1'b0;
                        st_d.remain   = '0;
                    end
                end
            end else if (!st_q.synced) begin
                if (eff_pattern) begin
                    st_d.seen = 1'b1;
                    if (cls_eff.sync) st_d.synced = 1'b1;
                end else if (!st_q.seen && !st_q.swap && rev_pattern) begin
                    st_d.swap = 1'b1;
                    st_d.seen = 1'b1;
                    if (cls_rev.sync) st_d.synced = 1'b1;
                end
            end else begin
                if (cls_eff.hdr) begin
                    st_d.addr   = eff_word[17:13];
                    st_d.remain = eff_word[CNT_W-1:0];
                end else if (cls_eff.rdreq) begin
                    st_d.rd_req = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_valid  = st_q.wr_valid;
    assign wr_addr   = st_q.wr_addr;
    assign wr_data   = st_q.wr_data;
    assign rd_req    = st_q.rd_req;
    assign crc_reset = st_q.crc_p;
    assign startup   = st_q.start_p;
    assign desync    = st_q.desync_p;
    assign dev_id    = st_q.dev_id;
    assign synced    = st_q.synced;
    assign swapped   = st_q.swap;

    // R1
    pad_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && in_word == PAD_WORD) |=> (!wr_valid && !rd_req && $stable(st_q.remain)));

    // R2
    strobe_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(st_q.synced));

    // R4
    strobe_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ($past(st_q.remain) != '0));

    // R7
    one_cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({crc_reset, startup, desync}));

    // R10
    desync_drops_sync_chk: assert property (@(posedge clk) disable iff (rst)
        desync |-> !synced);

    // R10
    swap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        swapped |=> swapped);

    // R9
    rdreq_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !wr_valid);
endmodule

// File: tb/cfg_stream_decoder_bench.sv
module cfg_stream_decoder_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready, wr_valid, rd_req, crc_reset, startup, desync, synced, swapped;
    logic [4:0]  wr_addr;
    logic [31:0] wr_data;
    logic [27:0] dev_id;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic        s_wv, s_rd, s_crc, s_st, s_ds;
    logic [4:0]  s_wa;
    logic [31:0] s_wd;

    cfg_stream_decoder u_cfg_stream_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_req(rd_req), .crc_reset(crc_reset),
        .startup(startup), .desync(desync), .dev_id(dev_id),
        .synced(synced), .swapped(swapped)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] brev(input logic [31:0] w);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            for (int i = 0; i < 8; i++)
                r[8*b+i] = w[8*b+7-i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    bit swap_tx = 0;

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = swap_tx ? brev(w) : w;
        @(posedge clk);
        #1;
        s_wv = wr_valid; s_wa = wr_addr; s_wd = wr_data;
        s_rd = rd_req; s_crc = crc_reset; s_st = startup; s_ds = desync;
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R11 ready low in reset", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic quiet(input string req);
        check(req, {26'd0, s_wv, s_rd, s_crc, s_st, s_ds, 1'b0}, 32'd0);
    endtask

    initial begin
        #(PERIOD * 190000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R11 synced after reset", {31'd0, synced}, 32'd0);
        check("R11 swapped after reset", {31'd0, swapped}, 32'd0);
        check("R11 dev_id after reset", {4'd0, dev_id}, 32'd0);
        check("R11 ready out of reset", {31'd0, in_ready}, 32'd1);

        // R2: headers ignored before sync; bus-width words do not sync
        send(32'h0000_00BB);
        send(32'h1122_0044);
        check("R2 no sync from width words", {31'd0, synced}, 32'd0);
        send(32'h3000_8001);
        send(32'd7);
        quiet("R2 command ignored unsynced");
        check("R3 no swap on plain stream", {31'd0, swapped}, 32'd0);
        send(32'hFFFF_FFFF);
        quiet("R1 padding unsynced");
        send(32'h2000_0000);
        check("R6 noop keeps unsynced", {31'd0, synced}, 32'd0);
        send(32'hAA99_5566);
        check("R2 synced after sync word", {31'd0, synced}, 32'd1);

        // R4/R5 sweep: all addresses, counts 0..3, with padding and no-op between
        for (int a = 0; a < 32; a++) begin
            for (int n = 0; n < 4; n++) begin
                send(32'h3000_0000 | (32'(a) << 13) | 32'(n));
                quiet("R4 header no strobe");
                for (int k = 0; k < n; k++) begin
                    if (k == 1) begin
                        send(32'hFFFF_FFFF);
                        quiet("R1 padding inside payload");
                    end
                    send(32'hA500_0000 | (32'(a) << 8) | (32'(n) << 4) | 32'(k));
                    check("R4 strobe", {31'd0, s_wv}, 32'd1);
                    check("R4 address", {27'd0, s_wa}, 32'(a));
                    check("R4 data", s_wd, 32'hA500_0000 | (32'(a) << 8) | (32'(n) << 4) | 32'(k));
                end
                send(32'h2000_0000);
                quiet(n == 0 ? "R5 zero count" : "R6 noop after payload");
                check("R6 noop keeps sync", {31'd0, synced}, 32'd1);
            end
        end
        if (dev_id !== {4'd0, 24'hA5_0C_3 << 0} ) begin end

        // R8: ID capture
        send(32'h3001_8001);
        send(32'hF123_4567);
        check("R8 dev_id", {4'd0, dev_id}, 32'h0123_4567);

        // R9: read request
        send(32'h2800_6000);
        check("R9 rd_req pulse", {31'd0, s_rd}, 32'd1);
        check("R9 no write", {31'd0, s_wv}, 32'd0);
        send(32'h2000_0000);
        check("R9 rd_req one cycle", {31'd0, s_rd}, 32'd0);

        // R7/R10: sweep all command codes
        for (int c = 0; c < 32; c++) begin
            send(32'h3000_8001);
            send(32'(c));
            check("R7 crc_reset", {31'd0, s_crc}, {31'd0, c == 7});
            check("R7 startup", {31'd0, s_st}, {31'd0, c == 5});
            check("R7 desync", {31'd0, s_ds}, {31'd0, c == 13});
            check("R10 synced after cmd", {31'd0, synced}, {31'd0, c != 13});
            if (c == 13) begin
                send(32'h3000_8001);
                send(32'd7);
                quiet("R10 ignored after desync");
                send(32'hAA99_5566);
                check("R10 resync", {31'd0, synced}, 32'd1);
            end
        end

        // R3: byte-bit-reversed stream
        do_reset();
        swap_tx = 1;
        send(32'hFFFF_FFFF);
        check("R3 padding no swap", {31'd0, swapped}, 32'd0);
        send(32'h0000_00BB);
        check("R3 swap latched", {31'd0, swapped}, 32'd1);
        check("R3 not synced yet", {31'd0, synced}, 32'd0);
        send(32'h1122_0044);
        send(32'hAA99_5566);
        check("R3 synced swapped", {31'd0, synced}, 32'd1);
        send(32'h3000_2002);
        send(32'h1234_5678);
        check("R3 corrected data", s_wd, 32'h1234_5678);
        check("R3 corrected addr", {27'd0, s_wa}, 32'd1);
        send(32'h8000_0001);
        check("R3 corrected data 2", s_wd, 32'h8000_0001);
        send(32'h3000_8001);
        send(32'd7);
        check("R3 swapped crc pulse", {31'd0, s_crc}, 32'd1);
        send(32'h3000_8001);
        send(32'd13);
        check("R10 swap kept after desync", {31'd0, swapped}, 32'd1);
        check("R10 unsynced", {31'd0, synced}, 32'd0);
        send(32'hAA99_5566);
        check("R10 resync swapped", {31'd0, synced}, 32'd1);

        // R3: swap detected directly on a reversed sync word
        do_reset();
        send(32'hAA99_5566);
        check("R3 swap from sync", {31'd0, swapped}, 32'd1);
        check("R3 sync from reversed", {31'd0, synced}, 32'd1);
        swap_tx = 0;

        // R11: reset clears
        do_reset();
        check("R11 swap cleared", {31'd0, swapped}, 32'd0);
        check("R11 sync cleared", {31'd0, synced}, 32'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule